// File: doc/BRIEF.md
# Tagged Branch Target Buffer

This block predicts the next fetch address before the fetched word has been decoded. Each cycle it takes the current fetch PC and returns a predicted next PC. The prediction comes from a direct-mapped table of 2^IDX_W entries. Each entry stores a valid flag, the complete PC of a control instruction as its tag, a predicted target and a 2-bit saturating direction counter. When the fetch PC matches a valid entry exactly and that entry's counter leans taken, the stored target is returned. In every other case the sequential address PC+4 is returned. Because the whole PC is compared, an ordinary instruction whose address shares an index with a branch is never sent to that branch's target.

The execute stage reports each resolved instruction on a resolve port. The report carries its PC, a control-instruction flag, the actual direction, the actual target and the next PC that fetch used for it. In the same cycle the block compares the actual next PC with the one that was used. On a mismatch it raises a redirect, which kills the wrong-path instruction and restarts fetch at the correct address. On the clock edge that follows, the table is trained. Control instructions that hit have their counter moved. Taken control instructions that miss are allocated. Non-control instructions never touch the table.

Top module: `fetch_target_cache`

## Requirements
- R1: A synchronous reset clears every valid flag, so after reset every fetch PC predicts fetch_pc+4.
- R2: The table index is fetch_pc[IDX_W+1:2]. A lookup whose indexed entry is invalid predicts fetch_pc+4.
- R3: The stored tag is the full 32-bit PC. A fetch PC with the same index as a valid entry but a different address predicts fetch_pc+4.
- R4: On an exact tag hit, the prediction is the stored target when counter bit 1 is set (counter 2 or 3), and fetch_pc+4 when it is clear (counter 0 or 1).
- R5: A resolved control instruction that is taken and misses the table allocates its entry. The allocation sets valid, writes the tag and the target, and sets the counter to 2 (weakly taken).
- R6: A resolved control instruction that is not taken and misses the table leaves the table unchanged.
- R7: A resolved instruction whose control flag is 0 never changes the table, whatever its direction or target.
- R8: A resolved control instruction that hits moves its counter one step toward its actual direction. The counter saturates at 0 and at 3.
- R9: A resolved control instruction that hits, is taken, and was mispredicted has its stored target replaced by the actual target.
- R10: If a lookup and a resolve address the same entry in one cycle, the lookup returns the contents from before that resolve.
- R11: redirect is 1 exactly when rs_valid is 1 and the actual next PC differs from rs_pred_npc. The actual next PC is rs_target for a taken control instruction and rs_pc+4 otherwise. redirect_pc carries the actual next PC in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_pc | input | 32 | Address being fetched this cycle |
| pred_npc | output | 32 | Predicted next fetch address |
| pred_hit | output | 1 | The fetch PC matched a valid entry |
| rs_valid | input | 1 | A resolved instruction is reported |
| rs_pc | input | 32 | PC of the resolved instruction |
| rs_is_ctrl | input | 1 | The resolved instruction is a branch or jump |
| rs_taken | input | 1 | Actual direction, 1 = taken |
| rs_target | input | 32 | Actual taken target |
| rs_pred_npc | input | 32 | Next PC that fetch used after this instruction |
| redirect | output | 1 | Misprediction: kill and refetch |
| redirect_pc | output | 32 | Correct next PC |

## Verification
The bench first fills every entry and then probes every index with an aliasing address of the same index. A design that compared only the index bits would send those aliases to a stored target instead of PC+4. Counter patterns are driven on a number of entries to reach both saturation points and the taken/not-taken threshold. An off-by-one threshold, or a counter that wraps instead of saturating, shows up as a wrong prediction a few steps later. Three further cases each have a specific failure to catch:
- Not-taken misses and non-control reports sent to occupied indices would evict a live entry if the design trained on them.
- A lookup made in the same cycle as a write to its entry would return new data early if the table read were bypassed.
- A reset taken mid-run would leave stale hits if it did not clear every valid flag.

// File: rtl/fetch_target_cache.sv
module fetch_target_cache #(
  parameter int IDX_W = 7,
  parameter int AW    = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] fetch_pc,
  output logic [AW-1:0] pred_npc,
  output logic          pred_hit,
  input  logic          rs_valid,
  input  logic [AW-1:0] rs_pc,
  input  logic          rs_is_ctrl,
  input  logic          rs_taken,
  input  logic [AW-1:0] rs_target,
  input  logic [AW-1:0] rs_pred_npc,
  output logic          redirect,
  output logic [AW-1:0] redirect_pc
);
  localparam int N = 1 << IDX_W;

  logic [N-1:0]  vld;
  logic [AW-1:0] tag [N];
  logic [AW-1:0] tgt [N];
  logic [1:0]    ctr [N];

  wire [IDX_W-1:0] f_idx = fetch_pc[IDX_W+1:2];
  wire             f_hit = vld[f_idx] && (tag[f_idx] == fetch_pc);
  wire             f_take = f_hit && ctr[f_idx][1];

  assign pred_hit = f_hit;
  assign pred_npc = f_take ? tgt[f_idx] : fetch_pc + AW'(4);

  wire [IDX_W-1:0] r_idx    = rs_pc[IDX_W+1:2];
  wire             r_hit    = vld[r_idx] && (tag[r_idx] == rs_pc);
  wire [AW-1:0]    r_actual = (rs_is_ctrl && rs_taken) ? rs_target : rs_pc + AW'(4);
  wire [1:0]       r_ctr    = ctr[r_idx];

  assign redirect    = rs_valid && (r_actual != rs_pred_npc);
  assign redirect_pc = r_actual;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
    end else if (rs_valid && rs_is_ctrl) begin
      if (r_hit) begin
        if (rs_taken)
          ctr[r_idx] <= (r_ctr == 2'd3) ? 2'd3 : r_ctr + 2'd1;
        else
          ctr[r_idx] <= (r_ctr == 2'd0) ? 2'd0 : r_ctr - 2'd1;
        if (rs_taken && redirect)
          tgt[r_idx] <= rs_target;
      end else if (rs_taken) begin
        vld[r_idx] <= 1'b1;
        tag[r_idx] <= rs_pc;
        tgt[r_idx] <= rs_target;
        ctr[r_idx] <= 2'b10;
      end
    end
  end
endmodule

module fetch_target_cache_chk #(
  parameter int IDX_W = 7,
  parameter int AW    = 32
) (
  input logic                clk,
  input logic                rst,
  input logic [AW-1:0]       fetch_pc,
  input logic [AW-1:0]       pred_npc,
  input logic                rs_valid,
  input logic [AW-1:0]       rs_pc,
  input logic                rs_is_ctrl,
  input logic                rs_taken,
  input logic [AW-1:0]       rs_pred_npc,
  input logic                redirect,
  input logic [AW-1:0]       redirect_pc,
  input logic [(1<<IDX_W)-1:0] vld
);
  assert_reset_fallthrough_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> pred_npc == fetch_pc + AW'(4));

  assert_noctrl_no_write_R7: assert property (@(posedge clk) disable iff (rst)
    (rs_valid && !rs_is_ctrl) |=> $stable(vld));

  assert_nottaken_miss_no_alloc_R6: assert property (@(posedge clk) disable iff (rst)
    (rs_valid && rs_is_ctrl && !rs_taken && !vld[rs_pc[IDX_W+1:2]]) |=> $stable(vld));

  assert_redirect_needs_valid_R11: assert property (@(posedge clk) disable iff (rst)
    redirect |-> rs_valid);

  assert_redirect_differs_R11: assert property (@(posedge clk) disable iff (rst)
    redirect |-> redirect_pc != rs_pred_npc);

  assert_taken_alloc_R5: assert property (@(posedge clk) disable iff (rst)
    (rs_valid && rs_is_ctrl && rs_taken) |=> vld[$past(rs_pc[IDX_W+1:2])]);
endmodule

bind fetch_target_cache fetch_target_cache_chk #(.IDX_W(IDX_W), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .pred_npc(pred_npc),
  .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_is_ctrl(rs_is_ctrl),
  .rs_taken(rs_taken), .rs_pred_npc(rs_pred_npc), .redirect(redirect),
  .redirect_pc(redirect_pc), .vld(vld)
);

// File: tb/sim_fetch_target_cache.sv
module sim_fetch_target_cache;
  localparam int IDX_W = 7;
  localparam int N = 1 << IDX_W;
  localparam logic [31:0] BASE = 32'h1000_0000;
  localparam logic [31:0] TBASE = 32'h2000_0000;

  logic clk = 0;
  logic rst = 1;
  logic [31:0] fetch_pc = 0;
  logic [31:0] pred_npc;
  logic pred_hit;
  logic rs_valid = 0, rs_is_ctrl = 0, rs_taken = 0;
  logic [31:0] rs_pc = 0, rs_target = 0, rs_pred_npc = 0;
  logic redirect;
  logic [31:0] redirect_pc;

  int vectors = 0, fails = 0;
  bit done = 0;

  logic        mv [N];
  logic [31:0] mtag [N];
  logic [31:0] mt [N];
  logic [1:0]  mc [N];

  always #5 clk = ~clk;

  fetch_target_cache #(.IDX_W(IDX_W), .AW(32)) u0 (
    .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .pred_npc(pred_npc), .pred_hit(pred_hit),
    .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_is_ctrl(rs_is_ctrl), .rs_taken(rs_taken),
    .rs_target(rs_target), .rs_pred_npc(rs_pred_npc), .redirect(redirect),
    .redirect_pc(redirect_pc)
  );

  function automatic int ix(logic [31:0] pc);
    return int'(pc[IDX_W+1:2]);
  endfunction

  function automatic logic [31:0] mpred(logic [31:0] pc);
    int i = ix(pc);
    if (mv[i] && mtag[i] == pc && mc[i][1]) return mt[i];
    return pc + 32'd4;
  endfunction

  task automatic cmp(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic mclear();
    for (int i = 0; i < N; i++) mv[i] = 0;
  endtask

  task automatic mupdate(logic [31:0] pc, logic ctrl, logic tk, logic [31:0] tg, logic mis);
    int i = ix(pc);
    if (!ctrl) return;
    if (mv[i] && mtag[i] == pc) begin
      if (tk) mc[i] = (mc[i] == 2'd3) ? 2'd3 : mc[i] + 2'd1;
      else    mc[i] = (mc[i] == 2'd0) ? 2'd0 : mc[i] - 2'd1;
      if (tk && mis) mt[i] = tg;
    end else if (tk) begin
      mv[i] = 1; mtag[i] = pc; mt[i] = tg; mc[i] = 2'b10;
    end
  endtask

  task automatic look(string req, logic [31:0] pc);
    @(negedge clk);
    rs_valid = 0;
    fetch_pc = pc;
    #1 cmp(req, pred_npc, mpred(pc));
  endtask

  task automatic rsv(string req, logic [31:0] pc, logic ctrl, logic tk, logic [31:0] tg);
    logic [31:0] used, act;
    logic mis;
    @(negedge clk);
    used = mpred(pc);
    act = (ctrl && tk) ? tg : pc + 32'd4;
    mis = (act != used);
    rs_valid = 1; rs_pc = pc; rs_is_ctrl = ctrl; rs_taken = tk; rs_target = tg;
    rs_pred_npc = used;
    #1;
    cmp({req, " redirect (R11)"}, {31'd0, redirect}, {31'd0, mis});
    cmp({req, " redirect_pc (R11)"}, redirect_pc, act);
    mupdate(pc, ctrl, tk, tg, mis);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rs_valid = 0; rst = 1;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    mclear();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    mclear();
    do_reset();

    // R1/R2: empty table, all indices fall through
    for (int i = 0; i < N; i++) look("R1 R2 empty lookup", BASE + 32'(i*4));

    // R5: allocate every index with a taken control transfer
    for (int i = 0; i < N; i++) rsv("R5 alloc", BASE + 32'(i*4), 1, 1, TBASE + 32'(i*8));
    for (int i = 0; i < N; i++) look("R4 R5 hit taken", BASE + 32'(i*4));

    // R3: aliases with the same index and a different tag
    for (int i = 0; i < N; i++) look("R3 alias fallthrough", BASE + 32'(N*4) + 32'(i*4));

    // R8/R4: counter patterns on 16 entries
    for (int e = 0; e < 16; e++)
      for (int s = 0; s < 10; s++) begin
        rsv("R8 counter", BASE + 32'(e*4), 1, logic'(((e >> (s % 4)) & 1) ^ (s / 5)), TBASE + 32'(e*8));
        look("R4 R8 after train", BASE + 32'(e*4));
      end

    // R8 saturation walk on one entry
    for (int s = 0; s < 5; s++) begin rsv("R8 sat up", BASE + 32'd80, 1, 1, TBASE + 32'd160); look("R8 sat up", BASE + 32'd80); end
    for (int s = 0; s < 5; s++) begin rsv("R8 sat down", BASE + 32'd80, 1, 0, TBASE + 32'd160); look("R8 sat down", BASE + 32'd80); end
    rsv("R8 climb", BASE + 32'd80, 1, 1, TBASE + 32'd160); look("R4 counter1", BASE + 32'd80);
    rsv("R8 climb", BASE + 32'd80, 1, 1, TBASE + 32'd160); look("R4 counter2", BASE + 32'd80);

    // R9: target rewrite on a taken hit with a new target
    for (int i = 20; i < 28; i++) begin
      rsv("R9 new target", BASE + 32'(i*4), 1, 1, 32'h3000_0000 + 32'(i*16));
      look("R9 target used", BASE + 32'(i*4));
    end

    // R6: not-taken miss on occupied indices leaves them alone
    for (int i = 30; i < 40; i++) begin
      rsv("R6 nt miss", BASE + 32'(N*8) + 32'(i*4), 1, 0, 32'h4000_0000);
      look("R6 alias still miss", BASE + 32'(N*8) + 32'(i*4));
      look("R6 owner intact", BASE + 32'(i*4));
    end

    // R7: non-control reports never write
    for (int i = 40; i < 50; i++) begin
      rsv("R7 noctrl alias", BASE + 32'(N*12) + 32'(i*4), 0, 1, 32'h5000_0000);
      look("R7 alias still miss", BASE + 32'(N*12) + 32'(i*4));
      rsv("R7 noctrl on hit", BASE + 32'(i*4), 0, 0, 32'h5000_0000);
      look("R7 owner intact", BASE + 32'(i*4));
    end

    // R10: same-cycle lookup sees old contents
    for (int i = 60; i < 64; i++) begin
      logic [31:0] pc, old;
      pc = BASE + 32'(N*16) + 32'(i*4);
      @(negedge clk);
      old = mpred(pc);
      fetch_pc = pc;
      rs_valid = 1; rs_pc = pc; rs_is_ctrl = 1; rs_taken = 1;
      rs_target = 32'h6000_0000 + 32'(i*4); rs_pred_npc = old;
      #1 cmp("R10 same-cycle old", pred_npc, old);
      mupdate(pc, 1, 1, 32'h6000_0000 + 32'(i*4), 1);
      look("R10 next cycle new", pc);
    end

    // R11: no redirect without a valid report
    @(negedge clk);
    rs_valid = 0; rs_pc = BASE; rs_is_ctrl = 1; rs_taken = 1;
    rs_target = 32'h7777_0000; rs_pred_npc = 32'h0;
    #1 cmp("R11 idle no redirect", {31'd0, redirect}, 32'd0);

    // R1: reset mid-run clears everything
    do_reset();
    for (int i = 0; i < N; i++) look("R1 post reset", BASE + 32'(i*4));

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule